// File: doc/BRIEF.md
# Byte-Wide Configuration Receive Port

This block is the target side of a byte-wide configuration load path. An external host places a byte on an 8-bit bus and pulls a select line and a write line low. On each rising clock edge the port decides whether to take that byte. Taken bytes go to an internal consumer through a single-entry valid/ready slot. While the consumer holds that slot full and refuses it, the port raises a stall output. The host must then keep the same byte on the bus until stall falls.

The host may instead hold select low with write high. In that case the port drives a status byte onto the bus. If the write level flips between two successive edges while select stays low, the port enters an abort. It raises a sticky flag and ignores writes until select is released.

Control is a four-state machine:
- IDLE: select not sampled low.
- WRITE: select low, write low.
- READ: select low, write high.
- ABORT: a direction change occurred.

Transitions:
- IDLE goes to WRITE or READ according to the write line, once select is sampled low.
- WRITE goes to READ-direction abort (ABORT) when write is sampled high with select still low.
- READ goes to ABORT when write is sampled low with select still low.
- Every state returns to IDLE on any edge where select is high.

Top module: `cfg_par_rx`

## Requirements
- R1: On a rising edge with sel_n=0, wr_n=0 and stall=0, and with no abort active or being entered, host_d is captured. After that edge cfg_valid=1 and cfg_byte equals the captured byte.
- R2: stall is 1 exactly when cfg_valid=1 and cfg_ready=0. A byte presented at an edge where stall=1 is ignored, and cfg_byte holds its value.
- R3: The slot empties at an edge where cfg_valid=1 and cfg_ready=1, unless a new byte is captured at that same edge. Back-to-back bytes with cfg_ready=1 are taken one per clock.
- R4: If sel_n is 0 at two successive edges and wr_n differs between them, abort_flag is 1 after the second edge. This holds for a change from write to read and for a change from read to write.
- R5: While abort_flag=1 and sel_n stays 0, no byte is captured and abort_flag stays 1.
- R6: abort_flag is 0 after any edge at which sel_n is sampled 1.
- R7: host_oe is 1 exactly when sel_n=0 and wr_n=1, combinationally. While it is 1, host_q carries the status byte: bit 7 = abort_flag, bit 6 = stall, bit 5 = cfg_valid, bits 4..0 = 0.
- R8: A synchronous active-high rst clears cfg_byte to 0 and clears cfg_valid, stall and abort_flag.
- R9: With sel_n=1 no byte is captured, whatever the level of wr_n.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_d | input | 8 | Byte from host |
| sel_n | input | 1 | Select, active low |
| wr_n | input | 1 | Write strobe, active low; high selects read direction |
| stall | output | 1 | Host must hold its byte |
| host_q | output | 8 | Status byte driven toward host |
| host_oe | output | 1 | Enable for host_q |
| cfg_byte | output | 8 | Byte to consumer |
| cfg_valid | output | 1 | cfg_byte holds an untaken byte |
| cfg_ready | input | 1 | Consumer takes the byte this edge |
| abort_flag | output | 1 | Sticky abort indication |

## Verification
The properties assume that the host changes sel_n, wr_n and host_d only between edges. They also assume that cfg_ready is a plain level from the consumer, with no dependence on stall.

The stimulus drives every input a short time after the rising edge. It changes cfg_ready only between edges, and it never turns the bus around except in the abort scenarios, where a direction flip is the point of the test. Reset is applied only at the start of a run and once mid-run, and in both cases it is held across a full edge.

// File: rtl/cfg_par_rx_pkg.sv
package cfg_par_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_ABORT = 2'd3
    } rx_state_t;

    localparam int STAT_ABORT_BIT = 7;
    localparam int STAT_STALL_BIT = 6;
    localparam int STAT_VALID_BIT = 5;
endpackage

// File: rtl/cfg_par_rx_fsm.sv
module cfg_par_rx_fsm
    import cfg_par_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_n,
    input  logic      wr_n,
    output rx_state_t state,
    output logic      load_req,
    output logic      abort_on
);
    rx_state_t state_q;
    rx_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (sel_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = wr_n ? ST_READ : ST_WRITE;
                ST_WRITE: state_d = wr_n ? ST_ABORT : ST_WRITE;
                ST_READ:  state_d = wr_n ? ST_READ : ST_ABORT;
                ST_ABORT: state_d = ST_ABORT;
            endcase
        end
    end

    always_comb begin
        load_req = 1'b0;
        abort_on = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_req = !sel_n && !wr_n;
            ST_WRITE: load_req = !sel_n && !wr_n;
            ST_READ:  load_req = 1'b0;
            ST_ABORT: abort_on = 1'b1;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/cfg_par_rx_slot.sv
module cfg_par_rx_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic [DATA_W-1:0] din,
    output logic              stall,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    input  logic              dout_ready
);
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              accept;
    logic              drain;

    assign stall  = valid_q && !dout_ready;
    assign drain  = valid_q && dout_ready;
    assign accept = load_req && !stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (accept) begin
                data_q  <= din;
                valid_q <= 1'b1;
            end else if (drain) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign dout       = data_q;
    assign dout_valid = valid_q;
endmodule

// File: rtl/cfg_par_rx_status.sv
module cfg_par_rx_status
    import cfg_par_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              abort_on,
    input  logic              stall,
    input  logic              valid,
    output logic [DATA_W-1:0] q,
    output logic              oe
);
    always_comb begin
        q = '0;
        q[STAT_ABORT_BIT] = abort_on;
        q[STAT_STALL_BIT] = stall;
        q[STAT_VALID_BIT] = valid;
    end

    assign oe = !sel_n && wr_n;
endmodule

// File: rtl/cfg_par_rx.sv
module cfg_par_rx
    import cfg_par_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] host_d,
    input  logic              sel_n,
    input  logic              wr_n,
    output logic              stall,
    output logic [DATA_W-1:0] host_q,
    output logic              host_oe,
    output logic [DATA_W-1:0] cfg_byte,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    output logic              abort_flag
);
    rx_state_t state;
    logic      load_req;
    logic      abort_on;

    cfg_par_rx_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sel_n    (sel_n),
        .wr_n     (wr_n),
        .state    (state),
        .load_req (load_req),
        .abort_on (abort_on)
    );

    cfg_par_rx_slot #(.DATA_W(DATA_W)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .load_req   (load_req),
        .din        (host_d),
        .stall      (stall),
        .dout       (cfg_byte),
        .dout_valid (cfg_valid),
        .dout_ready (cfg_ready)
    );

    cfg_par_rx_status #(.DATA_W(DATA_W)) u_stat (
        .sel_n    (sel_n),
        .wr_n     (wr_n),
        .abort_on (abort_on),
        .stall    (stall),
        .valid    (cfg_valid),
        .q        (host_q),
        .oe       (host_oe)
    );

    assign abort_flag = abort_on;
endmodule

// File: rtl/cfg_par_rx_chk.sv
module cfg_par_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] host_d,
    input logic              sel_n,
    input logic              wr_n,
    input logic              stall,
    input logic [DATA_W-1:0] host_q,
    input logic              host_oe,
    input logic [DATA_W-1:0] cfg_byte,
    input logic              cfg_valid,
    input logic              cfg_ready,
    input logic              abort_flag
);
    logic seen_sel;
    logic seen_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_sel <= 1'b0;
            seen_wr  <= 1'b0;
        end else begin
            seen_sel <= !sel_n;
            seen_wr  <= wr_n;
        end
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wr_n && !stall && !abort_flag && !(seen_sel && seen_wr))
        |=> (cfg_valid && cfg_byte == $past(host_d)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        stall |=> (cfg_valid && $stable(cfg_byte)));

    p_drain_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_ready && sel_n) |=> !cfg_valid);

    p_abort_set_r4: assert property (@(posedge clk) disable iff (rst)
        (seen_sel && !sel_n && (wr_n != seen_wr)) |=> abort_flag);

    p_abort_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (abort_flag && !sel_n) |=> (abort_flag && $stable(cfg_byte)));

    p_abort_clear_r6: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> !abort_flag);

    p_oe_dir_r7: assert property (@(posedge clk) disable iff (rst)
        host_oe |-> (!sel_n && wr_n && host_q[7] == abort_flag));

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (!cfg_valid && !abort_flag && cfg_byte == '0));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (sel_n && !cfg_valid) |=> !cfg_valid);
endmodule

bind cfg_par_rx cfg_par_rx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cfg_par_rx_tb.sv
module cfg_par_rx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_d = 8'h00;
    logic       sel_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       stall;
    logic [7:0] host_q;
    logic       host_oe;
    logic [7:0] cfg_byte;
    logic       cfg_valid;
    logic       cfg_ready = 1'b1;
    logic       abort_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cfg_par_rx u_dut (
        .clk(clk), .rst(rst), .host_d(host_d), .sel_n(sel_n), .wr_n(wr_n),
        .stall(stall), .host_q(host_q), .host_oe(host_oe),
        .cfg_byte(cfg_byte), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
        .abort_flag(abort_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        chk("R8 valid", cfg_valid, 0);
        chk("R8 byte", cfg_byte, 0);
        chk("R8 abort", abort_flag, 0);
        chk("R8 stall", stall, 0);
        chk("R7 oe idle", host_oe, 0);
        rst = 1'b0;
        step();
    endtask

    task automatic t_stream();
        cfg_ready = 1'b1;
        sel_n = 1'b0;
        wr_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            host_d = 8'hA1 + 8'(i);
            step();
            chk("R1 valid", cfg_valid, 1);
            chk("R3 back-to-back byte", cfg_byte, 32'(8'hA1 + 8'(i)));
        end
        sel_n = 1'b1;
        step();
        chk("R3 drained", cfg_valid, 0);
    endtask

    task automatic t_backpressure();
        cfg_ready = 1'b0;
        sel_n = 1'b0;
        wr_n = 1'b0;
        host_d = 8'hB1;
        step();
        chk("R1 byte", cfg_byte, 8'hB1);
        chk("R2 stall up", stall, 1);
        host_d = 8'hB2;
        step();
        chk("R2 ignored", cfg_byte, 8'hB1);
        chk("R2 still valid", cfg_valid, 1);
        cfg_ready = 1'b1;
        #1;
        chk("R2 stall drops", stall, 0);
        step();
        chk("R3 reload same edge", cfg_byte, 8'hB2);
        chk("R3 valid", cfg_valid, 1);
        sel_n = 1'b1;
        step();
        chk("R3 empty", cfg_valid, 0);
    endtask

    task automatic t_deselect();
        sel_n = 1'b1;
        wr_n = 1'b0;
        host_d = 8'hC1;
        step();
        step();
        chk("R9 no capture", cfg_valid, 0);
        chk("R9 byte kept", cfg_byte, 8'hB2);
    endtask

    task automatic t_abort_w2r();
        cfg_ready = 1'b1;
        sel_n = 1'b0;
        wr_n = 1'b0;
        host_d = 8'hD1;
        step();
        chk("R1 byte", cfg_byte, 8'hD1);
        wr_n = 1'b1;
        step();
        chk("R4 abort write->read", abort_flag, 1);
        chk("R7 oe", host_oe, 1);
        chk("R7 status", host_q, 8'h80);
        wr_n = 1'b0;
        host_d = 8'hD2;
        #1;
        chk("R7 oe off when writing", host_oe, 0);
        step();
        step();
        chk("R5 held", abort_flag, 1);
        chk("R5 ignored", cfg_valid, 0);
        chk("R5 byte", cfg_byte, 8'hD1);
        sel_n = 1'b1;
        step();
        chk("R6 cleared", abort_flag, 0);
    endtask

    task automatic t_abort_r2w();
        cfg_ready = 1'b0;
        sel_n = 1'b0;
        wr_n = 1'b0;
        host_d = 8'hE1;
        step();
        sel_n = 1'b1;
        step();
        sel_n = 1'b0;
        wr_n = 1'b1;
        step();
        chk("R4 no abort from idle", abort_flag, 0);
        chk("R7 status busy", host_q, 8'h60);
        wr_n = 1'b0;
        step();
        chk("R4 abort read->write", abort_flag, 1);
        chk("R5 byte", cfg_byte, 8'hE1);
        rst = 1'b1;
        step();
        chk("R8 mid reset valid", cfg_valid, 0);
        chk("R8 mid reset abort", abort_flag, 0);
        chk("R8 mid reset byte", cfg_byte, 0);
        rst = 1'b0;
        sel_n = 1'b1;
        cfg_ready = 1'b1;
        step();
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2;
        t_reset();
        t_stream();
        t_backpressure();
        t_deselect();
        t_abort_w2r();
        t_abort_r2w();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule